// File: doc/BRIEF.md
# Interleaved Element Distribution Address Unit

This block spreads one contiguous memory region over a set of processors so that, in every group of consecutive items as wide as the processor count, the item in slot p belongs to processor p. A define command sets the region's start address and the item size, given as a power-of-two exponent, and puts every processor on the first group. A promote command carries a processor mask. It moves each selected processor on to the same slot in the next group and leaves the others where they are. A processor that finishes early can then take more work while slower ones keep their current item.

At any time a processor index can be placed on the query port, and the unit returns that processor's current item address, `base + (group * NPROC + p) * 2^code`, computed combinationally from the stored state. A command that cannot be honoured raises a one-cycle error pulse and changes no state. The command may carry an item-size code outside the supported range, or it may be a promote whose size code differs from the active one or that comes before any define.

Top module: `ilv_addr_unit`

## Requirements
- R1: After reset every group counter is zero, the active base is 0, the active size code is 0, no define is active and `err_o` is low, so querying processor p returns address p.
- R2: A define with a size code of 6 or less loads the base and size code and sets all group counters to zero, and `err_o` stays low. From the next cycle a query for processor p returns `base + p * 2^code`.
- R3: The item size is 2 raised to the size code, for every code from 0 to 6.
- R4: A promote (`cmd_op` = 1) whose size code equals the active code advances by one group exactly those processors whose `cmd_mask` bit is 1. Each such processor's address grows by `NPROC * 2^code`, and the other processors keep their addresses.
- R5: A promote never changes a processor's slot within its group: after any sequence of promotes, the address of processor p minus the base equals `(g * NPROC + p) * 2^code`, where g is the number of promotes that selected p since the last define.
- R6: A promote whose size code differs from the active code raises `err_o` and changes no counter and no address.
- R7: A define (`cmd_op` = 0) with a size code above 6 raises `err_o` and leaves the base, the size code and all counters unchanged.
- R8: A promote issued when no define has been accepted since reset raises `err_o` and changes no address.
- R9: `err_o` is high for exactly the one cycle after a rejected command is sampled, and low after every accepted command.
- R10: A group counter is `GW` bits wide and wraps to zero after 2^GW promotes of its processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 1 | 0 = define, 1 = promote under mask |
| cmd_base | input | AW | Region start address (define only) |
| cmd_size | input | CW | Item-size exponent |
| cmd_mask | input | NPROC | Processors to promote (promote only) |
| qry_proc | input | PW | Processor index to look up |
| qry_addr | output | AW | Current item address of `qry_proc` |
| err_o | output | 1 | One-cycle pulse after a rejected command |

## Verification
On every cycle, the checker shows that an accepted define clears every counter and loads the base. It shows that a promote moves each masked processor by exactly one group and leaves each unmasked one alone. It also shows that an error pulse always follows a command and never comes with a state change, and that the active size code never leaves the legal range. The composed address arithmetic, where group, slot and exponent combine into a byte address, can only be shown by the bench's sweeps over all processors and all legal codes. The same holds for the counter wrap after a long run of promotes and for the rejection of each illegal code.

// File: rtl/ilv_pkg.sv
// Shared definitions for the interleaved address unit.
// Assumes: a one-bit command opcode.
package ilv_pkg;
    typedef enum logic {
        OP_DEFINE  = 1'b0,
        OP_PROMOTE = 1'b1
    } ilv_op_e;
endpackage

// File: rtl/ilv_cfg_reg.sv
// Holds the active region configuration (base, size exponent, defined
// flag), classifies each command as an accepted define, an accepted
// promote or a rejection, and registers the error pulse.
// Assumes: the command is qualified by cmd_valid for exactly one cycle.
module ilv_cfg_reg #(
    parameter int AW       = 48,
    parameter int CW       = 4,
    parameter int MAX_CODE = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_op,
    input  logic [AW-1:0] cmd_base,
    input  logic [CW-1:0] cmd_size,
    output logic [AW-1:0] act_base,
    output logic [CW-1:0] act_code,
    output logic          act_defined,
    output logic          def_ok,
    output logic          prm_ok,
    output logic          err_o
);
    import ilv_pkg::*;

    logic size_legal;
    logic reject;

    // Decide whether the presented command can be honoured.
    always_comb begin
        size_legal = (cmd_size <= CW'(MAX_CODE));
        def_ok     = cmd_valid && (cmd_op == OP_DEFINE) && size_legal;
        prm_ok     = cmd_valid && (cmd_op == OP_PROMOTE) && act_defined
                     && (cmd_size == act_code);
        reject     = cmd_valid && !def_ok && !prm_ok;
    end

    // Capture the region configuration on an accepted define.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_base    <= '0;
            act_code    <= '0;
            act_defined <= 1'b0;
        end else if (def_ok) begin
            act_base    <= cmd_base;
            act_code    <= cmd_size;
            act_defined <= 1'b1;
        end
    end

    // Pulse the error flag for one cycle after a rejected command.
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= reject;
    end
endmodule

// File: rtl/ilv_grp_ctr.sv
// One group counter per processor: cleared together by a define, and
// advanced individually by a promote according to the mask.
// Assumes: clr and adv are never both high (they come from exclusive ops).
module ilv_grp_ctr #(
    parameter int NPROC = 64,
    parameter int GW    = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                adv,
    input  logic [NPROC-1:0]    mask,
    output logic [NPROC*GW-1:0] grp_flat
);
    for (genvar i = 0; i < NPROC; i++) begin : g_cnt
        logic [GW-1:0] cnt_q;

        // Clear on define, step on a selecting promote, wrap naturally.
        always_ff @(posedge clk) begin
            if (!rst_n)                cnt_q <= '0;
            else if (clr)              cnt_q <= '0;
            else if (adv && mask[i])   cnt_q <= cnt_q + GW'(1);
        end

        assign grp_flat[i*GW +: GW] = cnt_q;
    end
endmodule

// File: rtl/ilv_addr_calc.sv
// Combinational address of the queried processor:
// base + ((group * NPROC) + slot) << code.
// Assumes: NPROC is a power of two, so group and slot concatenate into the
// linear item index; the result wraps modulo 2^AW.
module ilv_addr_calc #(
    parameter int NPROC = 64,
    parameter int AW    = 48,
    parameter int GW    = 12,
    parameter int CW    = 4,
    localparam int PW   = $clog2(NPROC),
    localparam int IW   = GW + PW
) (
    input  logic [AW-1:0]       act_base,
    input  logic [CW-1:0]       act_code,
    input  logic [NPROC*GW-1:0] grp_flat,
    input  logic [PW-1:0]       qry_proc,
    output logic [AW-1:0]       qry_addr
);
    logic [GW-1:0] sel_grp;
    logic [IW-1:0] item_idx;
    logic [AW-1:0] byte_off;

    // Pick the processor's group, form the item index and scale it.
    always_comb begin
        sel_grp  = grp_flat[qry_proc*GW +: GW];
        item_idx = {sel_grp, qry_proc};
        byte_off = AW'(item_idx) << act_code;
        qry_addr = act_base + byte_off;
    end
endmodule

// File: rtl/ilv_addr_unit.sv
// Interleaved element distribution address unit (top). Accepts define and
// promote-under-mask commands and answers per-processor address queries.
// Assumes: NPROC is a power of two and GW + PW + MAX_CODE <= AW.
module ilv_addr_unit #(
    parameter int NPROC    = 64,
    parameter int AW       = 48,
    parameter int GW       = 12,
    parameter int CW       = 4,
    parameter int MAX_CODE = 6,
    localparam int PW      = $clog2(NPROC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_op,
    input  logic [AW-1:0]    cmd_base,
    input  logic [CW-1:0]    cmd_size,
    input  logic [NPROC-1:0] cmd_mask,
    input  logic [PW-1:0]    qry_proc,
    output logic [AW-1:0]    qry_addr,
    output logic             err_o
);
    logic [AW-1:0]       act_base;
    logic [CW-1:0]       act_code;
    logic                act_defined;
    logic                def_ok;
    logic                prm_ok;
    logic [NPROC*GW-1:0] grp_flat;

    ilv_cfg_reg #(.AW(AW), .CW(CW), .MAX_CODE(MAX_CODE)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_base    (cmd_base),
        .cmd_size    (cmd_size),
        .act_base    (act_base),
        .act_code    (act_code),
        .act_defined (act_defined),
        .def_ok      (def_ok),
        .prm_ok      (prm_ok),
        .err_o       (err_o)
    );

    ilv_grp_ctr #(.NPROC(NPROC), .GW(GW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (def_ok),
        .adv      (prm_ok),
        .mask     (cmd_mask),
        .grp_flat (grp_flat)
    );

    ilv_addr_calc #(.NPROC(NPROC), .AW(AW), .GW(GW), .CW(CW)) u_calc (
        .act_base (act_base),
        .act_code (act_code),
        .grp_flat (grp_flat),
        .qry_proc (qry_proc),
        .qry_addr (qry_addr)
    );
endmodule

// File: rtl/ilv_addr_unit_chk.sv
// Property checker for ilv_addr_unit, attached by bind below.
// Assumes: it observes the top's ports and internal configuration state.
module ilv_addr_unit_chk #(
    parameter int NPROC    = 64,
    parameter int AW       = 48,
    parameter int GW       = 12,
    parameter int CW       = 4,
    parameter int MAX_CODE = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic                cmd_op,
    input logic [AW-1:0]       cmd_base,
    input logic [CW-1:0]       cmd_size,
    input logic [NPROC-1:0]    cmd_mask,
    input logic                err_o,
    input logic [AW-1:0]       act_base,
    input logic [CW-1:0]       act_code,
    input logic                act_defined,
    input logic [NPROC*GW-1:0] grp_flat
);
    import ilv_pkg::*;

    // R2: a legal define clears all counters and loads the base.
    p_define_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_DEFINE && cmd_size <= CW'(MAX_CODE))
        |=> (grp_flat == '0) && (act_base == $past(cmd_base)));

    // R3: the active size code never leaves the legal range.
    p_code_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act_defined |-> (act_code <= CW'(MAX_CODE)));

    // R6, R7, R8: a rejection changes no state.
    p_err_no_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($stable(grp_flat) && $stable(act_base) && $stable(act_code)));

    // R9: an error pulse is always caused by a command in the prior cycle.
    p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(cmd_valid));

    for (genvar i = 0; i < NPROC; i++) begin : g_proc
        // R4: a selected processor steps exactly one group.
        p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd_op == OP_PROMOTE && cmd_mask[i] && act_defined
             && cmd_size == act_code)
            |=> (grp_flat[i*GW +: GW] == $past(grp_flat[i*GW +: GW]) + GW'(1)));

        // R4: an unselected processor is left alone by a promote.
        p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd_op == OP_PROMOTE && !cmd_mask[i])
            |=> $stable(grp_flat[i*GW +: GW]));
    end
endmodule

bind ilv_addr_unit ilv_addr_unit_chk #(
    .NPROC(NPROC), .AW(AW), .GW(GW), .CW(CW), .MAX_CODE(MAX_CODE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_base    (cmd_base),
    .cmd_size    (cmd_size),
    .cmd_mask    (cmd_mask),
    .err_o       (err_o),
    .act_base    (act_base),
    .act_code    (act_code),
    .act_defined (act_defined),
    .grp_flat    (grp_flat)
);

// File: tb/test_ilv_addr_unit.sv
// Self-checking bench: sweeps every processor for every legal size code,
// several masks, all illegal codes and a full counter wrap.
module test_ilv_addr_unit;
    localparam int NPROC    = 64;
    localparam int AW       = 48;
    localparam int GW       = 12;
    localparam int CW       = 4;
    localparam int MAX_CODE = 6;
    localparam int PW       = $clog2(NPROC);
    localparam real HALF    = 2.5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic             cmd_op = 1'b0;
    logic [AW-1:0]    cmd_base = '0;
    logic [CW-1:0]    cmd_size = '0;
    logic [NPROC-1:0] cmd_mask = '0;
    logic [PW-1:0]    qry_proc = '0;
    logic [AW-1:0]    qry_addr;
    logic             err_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference model state.
    logic [AW-1:0] m_base = '0;
    int            m_code = 0;
    int            m_grp [NPROC];

    always #(HALF) clk = ~clk;

    ilv_addr_unit #(.NPROC(NPROC), .AW(AW), .GW(GW), .CW(CW),
                    .MAX_CODE(MAX_CODE)) i_ilv_addr_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_base(cmd_base), .cmd_size(cmd_size), .cmd_mask(cmd_mask),
        .qry_proc(qry_proc), .qry_addr(qry_addr), .err_o(err_o)
    );

    function automatic logic [AW-1:0] exp_addr(int p);
        logic [AW-1:0] idx;
        idx = AW'(m_grp[p]) * AW'(NPROC) + AW'(p);
        return m_base + idx * (AW'(1) << m_code);
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sweep(input string req);
        for (int p = 0; p < NPROC; p++) begin
            qry_proc = PW'(p);
            #0.5;
            check(qry_addr == exp_addr(p), req, qry_addr, exp_addr(p));
        end
    endtask

    task automatic do_cmd(input logic op, input logic [AW-1:0] b,
                          input int s, input logic [NPROC-1:0] m,
                          input bit exp_err, input string req);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_base = b;
        cmd_size = CW'(s); cmd_mask = m;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(err_o == exp_err, req, AW'(err_o), AW'(exp_err));
    endtask

    task automatic model_define(input logic [AW-1:0] b, input int s);
        m_base = b; m_code = s;
        for (int p = 0; p < NPROC; p++) m_grp[p] = 0;
    endtask

    task automatic model_promote(input logic [NPROC-1:0] m);
        for (int p = 0; p < NPROC; p++)
            if (m[p]) m_grp[p] = (m_grp[p] + 1) % (1 << GW);
    endtask

    initial begin
        for (int p = 0; p < NPROC; p++) m_grp[p] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check(err_o == 1'b0, "R1", AW'(err_o), '0);
        sweep("R1");

        // R8: promote before any define is rejected.
        do_cmd(1'b1, '0, 0, '1, 1'b1, "R8");
        sweep("R8");
        @(negedge clk);
        check(err_o == 1'b0, "R9", AW'(err_o), '0);

        for (int c = 0; c <= MAX_CODE; c++) begin
            logic [AW-1:0] b;
            logic [NPROC-1:0] ma;
            logic [NPROC-1:0] mb;
            b  = AW'(48'h0000_1000_0000) + AW'(c) * AW'(48'h12_3457);
            ma = {NPROC/4{4'b1010}} >> c;
            mb = {NPROC/8{8'b0000_1111}} ^ (NPROC'(1) << c);
            // R2, R3: define and sweep at group 0.
            do_cmd(1'b0, b, c, '0, 1'b0, "R9");
            model_define(b, c);
            sweep(c[0] ? "R3" : "R2");
            // R4, R5: masked promotes.
            do_cmd(1'b1, '0, c, ma, 1'b0, "R9");
            model_promote(ma);
            sweep("R4");
            do_cmd(1'b1, '0, c, mb, 1'b0, "R9");
            model_promote(mb);
            do_cmd(1'b1, '0, c, ma, 1'b0, "R9");
            model_promote(ma);
            sweep("R5");
            // R6: promote with a different size code.
            do_cmd(1'b1, '0, (c + 1) % (MAX_CODE + 1), '1, 1'b1, "R6");
            sweep("R6");
        end

        // R7: every illegal size code on define is rejected.
        for (int c = MAX_CODE + 1; c < (1 << CW); c++) begin
            do_cmd(1'b0, AW'(48'hFFFF_0000), c, '0, 1'b1, "R7");
            sweep("R7");
        end

        // R10: counter wrap on a single processor.
        do_cmd(1'b0, AW'(48'h0000_0020_0000), 3, '0, 1'b0, "R9");
        model_define(AW'(48'h0000_0020_0000), 3);
        for (int k = 0; k < (1 << GW) - 1; k++) begin
            do_cmd(1'b1, '0, 3, NPROC'(1) << 5, 1'b0, "R9");
            model_promote(NPROC'(1) << 5);
        end
        sweep("R10");
        do_cmd(1'b1, '0, 3, NPROC'(1) << 5, 1'b0, "R9");
        model_promote(NPROC'(1) << 5);
        qry_proc = PW'(5);
        #0.5;
        check(qry_addr == AW'(48'h0000_0020_0000) + AW'(5 * 8), "R10",
              qry_addr, AW'(48'h0000_0020_0000) + AW'(5 * 8));
        sweep("R10");

        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(HALF * 2 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule